// File: doc/BRIEF.md
# SPI Flash User-Mode Pass-Through Port

This block lets software drive an SPI flash one byte at a time. Each chip select owns a control register and a data window. When a control register holds the user-mode code, the window acts as a FIFO with no address meaning. A write to it is shifted out on the serial data output. A read returns the bytes shifted in from the serial data input. The chip select line is driven by the control register alone, so it stays low across any number of window accesses. Software lowers it by writing the user-mode code with the stop bit set and then clear. It raises it again by setting the stop bit.

A global configuration register holds one write-permit bit per chip select. A window write to a chip select whose permit bit is clear is acknowledged without any serial activity. The bus acknowledge for a window access is held back until the last bit has been shifted, so back-to-back accesses never overlap on the wire. A 3-byte-address flash command fits in a single 4-byte write. A 4-byte-address command takes a 1-byte opcode write followed by a 4-byte address write.

The engine is one state machine with four states:
- `ST_IDLE` waits for a request.
- `ST_LOW` holds the serial clock low while the output bit is set up.
- `ST_HIGH` holds the clock high after the input bit has been sampled.
- `ST_ACK` presents the one-cycle acknowledge.

The transitions are:
- IDLE→LOW when a window access is served.
- IDLE→ACK for a register access or a dropped window access.
- LOW→HIGH when the low half-period ends, and the input bit is sampled on this transition.
- HIGH→LOW when the high half-period ends and bits remain.
- HIGH→ACK when the high half-period of the final bit ends.
- ACK→IDLE always.

Top module: `spi_user_port`

## Requirements
- R1: After reset every `spi_cs_n` bit is high; `spi_sclk`, `spi_mosi` and `bus_ack` are low; the configuration register and all control registers read as zero.
- R2: A register access has `bus_win` low and word index `bus_addr[3:2]`. Index 0 is the configuration register, and index 1+n is the control register of chip select n. `bus_ack` is high in the cycle after the request. A register read returns the stored value in `bus_rdata` with that acknowledge.
- R3: `spi_cs_n[n]` is low exactly when control register n has bits 1:0 equal to 3 (user mode) and bit 2 (stop) equal to 0. It changes in the cycle after a register write and at no other time.
- R4: A served window write sends its bytes in ascending lane order, with lane 0 in `bus_wdata[7:0]` first and each byte MSB first. Each bit spends HALF_CYC cycles with `spi_sclk` low and then HALF_CYC cycles high, and `spi_mosi` changes only while `spi_sclk` is low.
- R5: `bus_size` 0, 1 and 2 move 1, 2 and 4 bytes. The window address bits below bit WIN_BITS have no effect on the access. Bit WIN_BITS selects the chip select.
- R6: A window write to chip select n while configuration bit 16+n is clear produces no `spi_sclk` edge and is acknowledged in the next cycle.
- R7: During a served window read `spi_mosi` is high. `spi_miso` is sampled as `spi_sclk` rises, and the first byte received lands in `bus_rdata[7:0]`, MSB first. Lanes beyond the access size read as zero.
- R8: A window access to a chip select whose control bits 1:0 are not 3 produces no serial activity, is acknowledged in the next cycle, and returns zero.
- R9: `bus_ack` is a single-cycle pulse. For a served access it rises in the cycle after the last high half-period. A window write returns zero data.
- R10: A 3-byte-address command sent as one 4-byte write, and a 4-byte-address command sent as a 1-byte write then a 4-byte write, each produce the expected serial byte stream while the chip select stays low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | One-cycle request strobe, issued only while idle |
| bus_win | input | 1 | 1: data window access, 0: register access |
| bus_we | input | 1 | 1: write, 0: read |
| bus_addr | input | CS_W+WIN_BITS | Register word index in bits 3:2, or chip select and ignored offset for the window |
| bus_size | input | 2 | Window access size: 0 one byte, 1 two bytes, 2 four bytes |
| bus_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Access-complete pulse |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The hardest state to reach is a chip select held low across several window accesses of different sizes. The data on the wire must stay correct through this, including when one chip select is in user mode without write permission and another is idle. The stimulus walks the control registers through the stop-bit sequence first. It then interleaves opcode-only, address-only and full-word accesses, so that the flash command forms and the dropped-write path are exercised while the line stays asserted. A behavioural flash model returns known bytes on the input line, so the lane ordering of reads can be checked.

// File: rtl/spi_up_pkg.sv
package spi_up_pkg;

    // Engine states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_ACK  = 2'd3
    } up_state_e;

    localparam int unsigned DATA_W    = 32;
    localparam logic [1:0]  MODE_USER = 2'b11;
    localparam int unsigned STOP_BIT  = 2;

    // Index of the last byte lane for a given size code
    function automatic logic [1:0] last_lane(input logic [1:0] size);
        unique case (size)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/spi_up_regs.sv
module spi_up_regs
    import spi_up_pkg::*;
#(
    parameter int unsigned NUM_CS  = 2,
    parameter int unsigned WE_BASE = 16,
    parameter int unsigned RIDX_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [RIDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_CS-1:0]   user_mode,
    output logic [NUM_CS-1:0]   wr_ok,
    output logic [NUM_CS-1:0]   cs_n
);

    logic [DATA_W-1:0] ctrl_q [NUM_CS];
    logic [NUM_CS-1:0] perm_q;

    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[n] <= '0;
                perm_q[n] <= 1'b0;
            end else if (wr_en) begin
                if (idx == RIDX_W'(n + 1)) ctrl_q[n] <= wdata;
                if (idx == '0)             perm_q[n] <= wdata[WE_BASE + n];
            end
        end

        assign user_mode[n] = (ctrl_q[n][1:0] == MODE_USER);
        assign wr_ok[n]     = perm_q[n];
        assign cs_n[n]      = !(user_mode[n] && !ctrl_q[n][STOP_BIT]);

        // The select line moves only as a result of a register write
        p_cs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(cs_n[n]));
    end

    always_comb begin
        rdata = '0;
        if (idx == '0) begin
            for (int n = 0; n < NUM_CS; n++) rdata[WE_BASE + n] = perm_q[n];
        end else begin
            for (int n = 0; n < NUM_CS; n++)
                if (idx == RIDX_W'(n + 1)) rdata = ctrl_q[n];
        end
    end

endmodule

// File: rtl/spi_up_fsm.sv
module spi_up_fsm
    import spi_up_pkg::*;
#(
    parameter int unsigned NUM_CS   = 2,
    parameter int unsigned CS_W     = 1,
    parameter int unsigned HALF_CYC = 2,
    parameter int unsigned WIN_BITS = 13,
    parameter int unsigned RIDX_W   = 2,
    parameter int unsigned ADDR_W   = CS_W + WIN_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_win,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ack,
    output logic                reg_wr,
    output logic [RIDX_W-1:0]   reg_idx,
    input  logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_CS-1:0]   user_mode,
    input  logic [NUM_CS-1:0]   wr_ok,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso
);

    localparam int unsigned HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    up_state_e         state_q, state_d;
    logic [HC_W-1:0]   cnt_q;
    logic [1:0]        bidx_q, last_q;
    logic [2:0]        bitn_q;
    logic              rd_q;
    logic [DATA_W-1:0] txw_q, rxw_q, rdata_q;

    logic [CS_W-1:0]   win_cs;
    logic              cs_ok, mode_sel, perm_sel, win_go, half_end;
    logic [4:0]        bit_sel;
    logic              unused_addr;

    // Window offset bits and the low register bits carry no meaning
    assign unused_addr = ^{bus_addr[1:0], bus_addr[WIN_BITS-1:RIDX_W+2]};

    assign reg_idx  = bus_addr[RIDX_W+1:2];
    assign win_cs   = bus_addr[WIN_BITS +: CS_W];
    assign cs_ok    = (32'(win_cs) < NUM_CS);
    assign mode_sel = cs_ok && user_mode[win_cs];
    assign perm_sel = cs_ok && wr_ok[win_cs];
    assign win_go   = mode_sel && (!bus_we || perm_sel);
    assign reg_wr   = (state_q == ST_IDLE) && bus_req && !bus_win && bus_we;
    assign half_end = (cnt_q == HC_W'(HALF_CYC - 1));
    assign bit_sel  = {bidx_q, bitn_q};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_req) state_d = (bus_win && win_go) ? ST_LOW : ST_ACK;
            ST_LOW:  if (half_end) state_d = ST_HIGH;
            ST_HIGH: if (half_end)
                         state_d = (bitn_q == 3'd0 && bidx_q == last_q) ? ST_ACK : ST_LOW;
            ST_ACK:  state_d = ST_IDLE;
        endcase
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bidx_q  <= '0;
            last_q  <= '0;
            bitn_q  <= 3'd7;
            rd_q    <= 1'b0;
            txw_q   <= '0;
            rxw_q   <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (bus_req) begin
                    cnt_q   <= '0;
                    bidx_q  <= '0;
                    bitn_q  <= 3'd7;
                    rxw_q   <= '0;
                    rd_q    <= !bus_we;
                    last_q  <= last_lane(bus_size);
                    txw_q   <= bus_we ? bus_wdata : '1;
                    rdata_q <= bus_win ? '0 : reg_rdata;
                end
                ST_LOW: begin
                    if (half_end) begin
                        cnt_q          <= '0;
                        rxw_q[bit_sel] <= spi_miso;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (half_end) begin
                        cnt_q <= '0;
                        if (bitn_q == 3'd0) begin
                            if (bidx_q == last_q) begin
                                rdata_q <= rd_q ? rxw_q : '0;
                            end else begin
                                bidx_q <= bidx_q + 1'b1;
                                bitn_q <= 3'd7;
                            end
                        end else begin
                            bitn_q <= bitn_q - 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ACK: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        bus_ack   = 1'b0;
        spi_sclk  = 1'b0;
        spi_mosi  = 1'b0;
        bus_rdata = rdata_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOW:  spi_mosi = txw_q[bit_sel];
            ST_HIGH: begin
                spi_sclk = 1'b1;
                spi_mosi = txw_q[bit_sel];
            end
            ST_ACK:  bus_ack = 1'b1;
        endcase
    end

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && $past(state_q) == ST_HIGH) |-> $stable(spi_mosi));

    p_rd_mosi_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && rd_q) |-> spi_mosi);

    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    p_drop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bus_req && bus_win && bus_we && !perm_sel)
        |=> (bus_ack && !spi_sclk));

    p_reg_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bus_req && !bus_win) |=> bus_ack);

    p_nomode_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bus_req && bus_win && !mode_sel)
        |=> (bus_ack && bus_rdata == '0));

endmodule

// File: rtl/spi_user_port.sv
module spi_user_port
    import spi_up_pkg::*;
#(
    parameter int unsigned NUM_CS   = 2,
    parameter int unsigned HALF_CYC = 2,
    parameter int unsigned WIN_BITS = 13,
    parameter int unsigned WE_BASE  = 16,
    localparam int unsigned CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned ADDR_W  = CS_W + WIN_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_win,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_ack,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic [NUM_CS-1:0]   spi_cs_n
);

    localparam int unsigned RIDX_W = $clog2(NUM_CS + 1);

    logic                reg_wr;
    logic [RIDX_W-1:0]   reg_idx;
    logic [DATA_W-1:0]   reg_rdata;
    logic [NUM_CS-1:0]   user_mode, wr_ok;

    spi_up_regs #(
        .NUM_CS  (NUM_CS),
        .WE_BASE (WE_BASE),
        .RIDX_W  (RIDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .idx       (reg_idx),
        .wdata     (bus_wdata),
        .rdata     (reg_rdata),
        .user_mode (user_mode),
        .wr_ok     (wr_ok),
        .cs_n      (spi_cs_n)
    );

    spi_up_fsm #(
        .NUM_CS   (NUM_CS),
        .CS_W     (CS_W),
        .HALF_CYC (HALF_CYC),
        .WIN_BITS (WIN_BITS),
        .RIDX_W   (RIDX_W),
        .ADDR_W   (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_win   (bus_win),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_rdata (reg_rdata),
        .user_mode (user_mode),
        .wr_ok     (wr_ok),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

endmodule

// File: tb/test_spi_user_port.sv
`timescale 1ns/1ps
module test_spi_user_port;

    localparam int HALF = 2;
    localparam int NCS  = 2;
    localparam int AW   = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_req, bus_win, bus_we;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          bus_ack, spi_sclk, spi_mosi, spi_miso;
    logic [NCS-1:0] spi_cs_n;

    always #2.5 clk = ~clk;

    spi_user_port #(.NUM_CS(NCS), .HALF_CYC(HALF), .WIN_BITS(13), .WE_BASE(16)) i_spi_user_port (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Expected per-cycle outputs
    bit          q_sclk[$], q_mosi[$], q_ack[$], q_chk[$];
    logic [31:0] q_rd[$];
    string       q_tag[$];

    // Behavioural register model
    logic [31:0]    m_ctrl [NCS];
    logic [NCS-1:0] m_we;

    // Flash model: presents reply bits, advancing on falling serial clock
    logic [31:0] srep = '0;
    int          spos = 0;
    always @(negedge spi_sclk) spos = spos + 1;
    assign spi_miso = (spos < 32) ? srep[(spos/8)*8 + 7 - (spos%8)] : 1'b0;

    task automatic push(bit s, bit m, bit a, bit c, logic [31:0] r, string t);
        q_sclk.push_back(s); q_mosi.push_back(m); q_ack.push_back(a);
        q_chk.push_back(c);  q_rd.push_back(r);   q_tag.push_back(t);
    endtask

    // Compare every cycle, 1 ns after the rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit          es, em, ea, ec;
            logic [31:0] er;
            string       et;
            logic [NCS-1:0] ecs;
            es = 0; em = 0; ea = 0; ec = 0; er = '0; et = "R1";
            if (q_sclk.size() > 0) begin
                es = q_sclk.pop_front(); em = q_mosi.pop_front(); ea = q_ack.pop_front();
                ec = q_chk.pop_front();  er = q_rd.pop_front();   et = q_tag.pop_front();
            end
            n_tests++;
            if ({spi_sclk, spi_mosi, bus_ack} !== {es, em, ea}) begin
                n_fail++;
                $display("FAIL %s: sclk/mosi/ack got %b%b%b expected %b%b%b at %0t",
                         et, spi_sclk, spi_mosi, bus_ack, es, em, ea, $time);
            end
            if (ec) begin
                n_tests++;
                if (bus_rdata !== er) begin
                    n_fail++;
                    $display("FAIL %s: rdata got %h expected %h", et, bus_rdata, er);
                end
            end
            for (int n = 0; n < NCS; n++)
                ecs[n] = !(m_ctrl[n][1:0] == 2'b11 && !m_ctrl[n][2]);
            n_tests++;
            if (spi_cs_n !== ecs) begin
                n_fail++;
                $display("FAIL R3: cs_n got %b expected %b at %0t", spi_cs_n, ecs, $time);
            end
        end
    end

    task automatic access(bit win, bit we, logic [AW-1:0] addr, logic [1:0] sz,
                          logic [31:0] wd, logic [31:0] rep, string tag);
        int          idx, cs, nb;
        bit          served, bv;
        logic [31:0] er;
        @(negedge clk);
        bus_req = 1; bus_win = win; bus_we = we; bus_addr = addr;
        bus_size = sz; bus_wdata = wd;
        er = '0;
        if (!win) begin
            idx = int'(addr[3:2]);
            if (idx == 0) begin
                for (int n = 0; n < NCS; n++) er[16+n] = m_we[n];
            end else if (idx <= NCS) begin
                er = m_ctrl[idx-1];
            end
            if (we) begin
                if (idx == 0) begin
                    for (int n = 0; n < NCS; n++) m_we[n] = wd[16+n];
                end else if (idx <= NCS) begin
                    m_ctrl[idx-1] = wd;
                end
            end
            push(0, 0, 1, !we, er, {tag, "/R9"});
        end else begin
            cs = int'(addr[13]);
            nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            served = (cs < NCS) && (m_ctrl[cs][1:0] == 2'b11) && (!we || m_we[cs]);
            if (served) begin
                srep = rep;
                spos = 0;
                for (int k = 0; k < nb; k++) begin
                    for (int b = 7; b >= 0; b--) begin
                        bv = we ? wd[8*k+b] : 1'b1;
                        if (!we) er[8*k+b] = rep[8*k+b];
                        repeat (HALF) push(0, bv, 0, 0, '0, tag);
                        repeat (HALF) push(1, bv, 0, 0, '0, tag);
                    end
                end
            end
            push(0, 0, 1, 1, er, {tag, "/R9"});
        end
        @(negedge clk);
        bus_req = 0; bus_we = 0; bus_win = 0;
        while (q_ack.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R9: watchdog expired, got no completion expected all accesses acknowledged");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < NCS; n++) m_ctrl[n] = '0;
        m_we = '0;
        rst_n = 0; bus_req = 0; bus_win = 0; bus_we = 0;
        bus_addr = '0; bus_size = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);                                  // R1 idle outputs

        access(0, 0, 14'h0000, 0, 0, 0, "R1");                       // config reads zero
        access(0, 0, 14'h0004, 0, 0, 0, "R1");                       // ctrl0 reads zero
        access(0, 1, 14'h0000, 0, 32'h0001_0000, 0, "R2");           // permit cs0 only
        access(0, 0, 14'h0000, 0, 0, 0, "R2");
        access(1, 1, 14'h0000, 2, 32'hDEAD_BEEF, 0, "R8");           // not in user mode
        access(1, 0, 14'h0000, 2, 0, 32'hFFFF_FFFF, "R8");
        access(0, 1, 14'h0004, 0, 32'h0000_0007, 0, "R3");           // user + stop
        access(0, 1, 14'h0004, 0, 32'h0000_0003, 0, "R3");           // select asserted
        access(0, 0, 14'h0004, 0, 0, 0, "R2");
        access(1, 1, 14'h0000, 2, 32'hA53C_0F81, 0, "R4");
        access(1, 1, 14'h1FFF, 0, 32'hFFFF_FF96, 0, "R5");           // offset ignored
        access(1, 1, 14'h0ABC, 1, 32'h0000_1234, 0, "R5");
        access(1, 0, 14'h0000, 2, 0, 32'h5AC3_01FE, "R7");
        access(1, 0, 14'h0123, 0, 0, 32'h0000_00B7, "R7");
        access(1, 0, 14'h0002, 1, 0, 32'h0000_6E19, "R7");
        access(1, 1, 14'h0000, 2, 32'h5634_1203, 0, "R10");          // 3-byte address form
        access(1, 1, 14'h0000, 0, 32'h0000_0013, 0, "R10");          // 4-byte address form
        access(1, 1, 14'h0000, 2, 32'h6745_2301, 0, "R10");
        access(0, 1, 14'h0008, 0, 32'h0000_0003, 0, "R3");           // cs1 user, no permit
        access(1, 1, 14'h2000, 2, 32'h1122_3344, 0, "R6");
        access(1, 0, 14'h2010, 1, 0, 32'h0000_C35A, "R7");
        access(0, 1, 14'h0004, 0, 32'h0000_0007, 0, "R3");           // release cs0
        access(0, 1, 14'h0004, 0, 32'h0000_0000, 0, "R3");           // back to read mode
        access(1, 0, 14'h0000, 2, 0, 32'hFFFF_FFFF, "R8");
        access(0, 0, 14'h0008, 0, 0, 0, "R2");
        repeat (4) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule